// File: doc/BRIEF.md
# Four-Bit Coupled Congruential Random Bit Source

This block produces pseudo-random bits from two linear congruential generators that run side by side modulo 2^W. The control generator's new state supplies one control bit per step, taken from its most significant bit. That bit decides how the most significant bit of the data generator's new state reaches the output: unchanged when the control bit is 1, inverted when it is 0.

Each multiplier has the form 2^r + 1. One step is therefore a left shift by r plus two W-bit additions, and no multiplier is needed. Four consecutive steps are chained inside one clock period. Every enabled cycle yields four output bits. The fourth state of each generator is registered and becomes the starting point for the next cycle.

A synchronous load replaces both generator states with seed values taken from the ports. The valid flag stays low through a warm-up of a parameterised number of enabled cycles after reset or a load, so that the first correlated outputs of a fresh seed are marked.

Top module: `clcg_bitgen`

## Requirements
- R1: After reset both generators hold the parameter reset seeds, rbits is 0 and rbits_valid is 0. The first enabled cycle then starts stepping from those seeds.
- R2: Each generator updates as x' = ((2^r + 1)·x + b) mod 2^W, with its own shift r and its own odd increment b. The least significant bit of a generator therefore toggles on every step.
- R3: For each step the control bit is the MSB of the control generator's new state. The output bit equals the MSB of the data generator's new state when the control bit is 1, and its inverse when the control bit is 0.
- R4: rbits[0] comes from the first of the four steps in a cycle and rbits[3] from the fourth.
- R5: Each enabled cycle advances both generators by exactly four steps. The next enabled cycle continues from the state reached after the fourth step, so no step is skipped or repeated.
- R6: While adv_en and seed_load are both 0, rbits, rbits_valid and the generator states do not change.
- R7: A cycle with seed_load at 1 loads seed_ctl and seed_dat into the two generators, clears rbits and clears rbits_valid. seed_load takes priority over adv_en.
- R8: rbits_valid rises with the output of the fourth enabled cycle after reset or a load. It stays 1 until the next load or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| adv_en | input | 1 | Advance both generators by four steps this cycle |
| seed_load | input | 1 | Load seeds, clear outputs and restart the warm-up |
| seed_ctl | input | W | Seed for the control generator |
| seed_dat | input | W | Seed for the data generator |
| rbits | output | 4 | Output bits; bit 0 from the earliest step |
| rbits_valid | output | 1 | High once the warm-up after reset or load is complete |

## Verification
The assertions assume that the increments are odd, that seed_load and adv_en are known values while the internal reset is released, and that inputs change only away from the rising edge. The stimulus drives every input at the falling edge. It keeps the parameter increments odd and releases reset only with both controls low. It then mixes enabled runs, idle gaps, loads while enabled and loads after the valid flag is already high, using seeds of zero, all ones and pseudo-random values. A sequential reference model using true multiplication predicts every four-bit result, so the predictions do not depend on the shift-and-add form used in the design.

// File: rtl/clcg_pkg.sv
package clcg_pkg;

  typedef enum logic [0:0] {
    PH_FILL = 1'b0,
    PH_RUN  = 1'b1
  } clcg_phase_e;

  // Coupling rule: pass the data MSB when the control bit is set, invert otherwise.
  function automatic logic couple_bit(input logic ctrl, input logic data_msb);
    return ctrl ? data_msb : ~data_msb;
  endfunction

endpackage

// File: rtl/clcg_rst_sync.sv
module clcg_rst_sync (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];

endmodule

// File: rtl/clcg_step.sv
module clcg_step #(
  parameter int unsigned    W     = 32,
  parameter int unsigned    SHIFT = 5,
  parameter logic [W-1:0]   INC   = 'h1
) (
  input  logic [W-1:0] cur_i,
  output logic [W-1:0] nxt_o
);

  logic [W-1:0] shifted;
  logic [W-1:0] partial;

  // Multiplier 2^SHIFT + 1: shift term plus (x + b), all wrapping mod 2^W.
  always_comb begin
    shifted = cur_i << SHIFT;
    partial = cur_i + INC;
    nxt_o   = shifted + partial;
  end

endmodule

// File: rtl/clcg_lane.sv
module clcg_lane
  import clcg_pkg::*;
#(
  parameter int unsigned  W      = 32,
  parameter int unsigned  SHIFT1 = 5,
  parameter int unsigned  SHIFT2 = 7,
  parameter logic [W-1:0] INC1   = 'h1,
  parameter logic [W-1:0] INC2   = 'h3
) (
  input  logic [W-1:0] ctl_cur_i,
  input  logic [W-1:0] dat_cur_i,
  output logic [W-1:0] ctl_nxt_o,
  output logic [W-1:0] dat_nxt_o,
  output logic         bit_o
);

  clcg_step #(.W(W), .SHIFT(SHIFT1), .INC(INC1)) u_ctl_step (
    .cur_i (ctl_cur_i),
    .nxt_o (ctl_nxt_o)
  );

  clcg_step #(.W(W), .SHIFT(SHIFT2), .INC(INC2)) u_dat_step (
    .cur_i (dat_cur_i),
    .nxt_o (dat_nxt_o)
  );

  always_comb bit_o = couple_bit(ctl_nxt_o[W-1], dat_nxt_o[W-1]);

endmodule

// File: rtl/clcg_warmup.sv
module clcg_warmup
  import clcg_pkg::*;
#(
  parameter int unsigned WARMUP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic adv_i,
  output logic valid_o
);

  localparam int unsigned CW = (WARMUP < 2) ? 1 : $clog2(WARMUP + 1);

  clcg_phase_e    phase_q, phase_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (clr_i) begin
      phase_d = PH_FILL;
      cnt_d   = '0;
    end else if (adv_i && (phase_q == PH_FILL)) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CW'(WARMUP - 1)) phase_d = PH_RUN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_FILL;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign valid_o = (phase_q == PH_RUN);

  // R8
  valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !clr_i |=> valid_o);

  // R8
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid_o) |-> $past(adv_i) && !$past(clr_i));

endmodule

// File: rtl/clcg_bitgen.sv
module clcg_bitgen #(
  parameter int unsigned  W         = 32,
  parameter int unsigned  LANES     = 4,
  parameter int unsigned  WARMUP    = LANES,
  parameter int unsigned  SHIFT1    = 5,
  parameter int unsigned  SHIFT2    = 7,
  parameter logic [W-1:0] INC1      = 'h3C6E_F35F,
  parameter logic [W-1:0] INC2      = 'h9E37_79B9,
  parameter logic [W-1:0] RST_SEED1 = 'h1234_5678,
  parameter logic [W-1:0] RST_SEED2 = 'h0BAD_F00D
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic             seed_load,
  input  logic [W-1:0]     seed_ctl,
  input  logic [W-1:0]     seed_dat,
  output logic [LANES-1:0] rbits,
  output logic             rbits_valid
);

  logic rst_s_n;

  clcg_rst_sync u_rst_sync (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_s_n)
  );

  logic [W-1:0]     ctl_q, ctl_d;
  logic [W-1:0]     dat_q, dat_d;
  logic [LANES-1:0] bits_q, bits_d;
  logic [W-1:0]     ctl_chain [0:LANES];
  logic [W-1:0]     dat_chain [0:LANES];
  logic [LANES-1:0] lane_bits;

  assign ctl_chain[0] = ctl_q;
  assign dat_chain[0] = dat_q;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    clcg_lane #(
      .W(W), .SHIFT1(SHIFT1), .SHIFT2(SHIFT2), .INC1(INC1), .INC2(INC2)
    ) u_lane (
      .ctl_cur_i (ctl_chain[k]),
      .dat_cur_i (dat_chain[k]),
      .ctl_nxt_o (ctl_chain[k+1]),
      .dat_nxt_o (dat_chain[k+1]),
      .bit_o     (lane_bits[k])
    );

    // R2
    ctl_parity_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      ctl_chain[k+1][0] != ctl_chain[k][0]);
    // R2
    dat_parity_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
      dat_chain[k+1][0] != dat_chain[k][0]);
  end

  always_comb begin
    ctl_d  = ctl_q;
    dat_d  = dat_q;
    bits_d = bits_q;
    if (seed_load) begin
      ctl_d  = seed_ctl;
      dat_d  = seed_dat;
      bits_d = '0;
    end else if (adv_en) begin
      ctl_d  = ctl_chain[LANES];
      dat_d  = dat_chain[LANES];
      bits_d = lane_bits;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctl_q  <= RST_SEED1;
      dat_q  <= RST_SEED2;
      bits_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      dat_q  <= dat_d;
      bits_q <= bits_d;
    end
  end

  clcg_warmup #(.WARMUP(WARMUP)) u_warmup (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .clr_i   (seed_load),
    .adv_i   (adv_en),
    .valid_o (rbits_valid)
  );

  assign rbits = bits_q;

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    !adv_en && !seed_load |=> $stable(rbits) && $stable(rbits_valid));

  // R7
  load_clear_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    seed_load |=> (rbits == '0) && !rbits_valid);

endmodule

// File: tb/clcg_bitgen_test.sv
module clcg_bitgen_test;

  localparam int unsigned W  = 32;
  localparam int unsigned L  = 4;
  localparam int unsigned WU = 4;
  localparam int unsigned S1 = 5;
  localparam int unsigned S2 = 7;
  localparam logic [W-1:0] B1  = 32'h3C6E_F35F;
  localparam logic [W-1:0] B2  = 32'h9E37_79B9;
  localparam logic [W-1:0] RS1 = 32'h1234_5678;
  localparam logic [W-1:0] RS2 = 32'h0BAD_F00D;

  logic clk = 1'b0;
  logic rst_n;
  logic adv_en, seed_load;
  logic [W-1:0] seed_ctl, seed_dat;
  logic [L-1:0] rbits;
  logic rbits_valid;

  always #10 clk = ~clk;

  clcg_bitgen #(
    .W(W), .LANES(L), .WARMUP(WU), .SHIFT1(S1), .SHIFT2(S2),
    .INC1(B1), .INC2(B2), .RST_SEED1(RS1), .RST_SEED2(RS2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .seed_load(seed_load),
    .seed_ctl(seed_ctl), .seed_dat(seed_dat),
    .rbits(rbits), .rbits_valid(rbits_valid)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [L-1:0] exp_bits_q [$];
  logic         exp_val_q  [$];
  string        exp_req_q  [$];

  logic [W-1:0] m_ctl, m_dat;
  logic [L-1:0] m_bits;
  logic         m_val;
  int           m_cnt;

  function automatic logic [W-1:0] ref_step(input logic [W-1:0] x,
                                             input int unsigned sh,
                                             input logic [W-1:0] b);
    logic [W-1:0] a;
    a = (W'(1) << sh) + W'(1);
    return a * x + b;
  endfunction

  task automatic model_reset();
    m_ctl = RS1; m_dat = RS2; m_bits = '0; m_val = 1'b0; m_cnt = 0;
  endtask

  // Driver: sets inputs at the falling edge and queues the result expected after the next rising edge.
  task automatic drive(input logic en, input logic ld,
                       input logic [W-1:0] s1, input logic [W-1:0] s2,
                       input string req);
    @(negedge clk);
    adv_en = en; seed_load = ld; seed_ctl = s1; seed_dat = s2;
    if (ld) begin
      m_ctl = s1; m_dat = s2; m_bits = '0; m_val = 1'b0; m_cnt = 0;
    end else if (en) begin
      for (int k = 0; k < L; k++) begin
        m_ctl = ref_step(m_ctl, S1, B1);
        m_dat = ref_step(m_dat, S2, B2);
        m_bits[k] = m_ctl[W-1] ? m_dat[W-1] : ~m_dat[W-1];
      end
      if (m_cnt < WU) m_cnt++;
      m_val = (m_cnt == WU);
    end
    exp_bits_q.push_back(m_bits);
    exp_val_q.push_back(m_val);
    exp_req_q.push_back(req);
    @(posedge clk);
  endtask

  // Monitor: compares each queued expectation shortly after the rising edge.
  always @(posedge clk) begin
    #1;
    if (exp_bits_q.size() > 0) begin
      logic [L-1:0] eb;
      logic         ev;
      string        rq;
      eb = exp_bits_q.pop_front();
      ev = exp_val_q.pop_front();
      rq = exp_req_q.pop_front();
      checks++;
      if (rbits !== eb || rbits_valid !== ev) begin
        errors++;
        $display("FAIL %s: rbits=%b valid=%b expected rbits=%b valid=%b",
                 rq, rbits, rbits_valid, eb, ev);
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; adv_en = 1'b0; seed_load = 1'b0; seed_ctl = '0; seed_dat = '0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state at the ports
    checks++;
    if (rbits !== '0 || rbits_valid !== 1'b0) begin
      errors++;
      $display("FAIL R1: rbits=%b valid=%b expected rbits=0000 valid=0", rbits, rbits_valid);
    end

    // R1, R5, R8: stepping from reset seeds, valid on the fourth enabled cycle
    for (int i = 0; i < 6; i++) drive(1'b1, 1'b0, '0, '0, "R1_R5_R8");
    // R6: idle gap holds everything
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 32'hFFFF_0000, 32'h0000_FFFF, "R6");
    // R5: continuation after the gap
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, '0, '0, "R5");

    // R7: load of zero seeds, then R2/R3/R4 from a known start
    drive(1'b0, 1'b1, '0, '0, "R7");
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, '0, '0, "R2_R3_R4");

    // R7: load has priority over enable, all-ones seeds
    drive(1'b1, 1'b1, '1, '1, "R7");
    for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, '0, '0, "R8");
    drive(1'b0, 1'b0, '0, '0, "R6");
    for (int i = 0; i < 2; i++) drive(1'b1, 1'b0, '0, '0, "R8");

    // R7, R8: load while valid is high restarts the warm-up
    drive(1'b0, 1'b1, 32'hDEAD_BEEF, 32'h0F0F_F0F0, "R7");
    for (int i = 0; i < 5; i++) drive(1'b1, 1'b0, '0, '0, "R8");

    // R2, R3, R4, R5, R6: pseudo-random seeds and enable patterns
    for (int n = 0; n < 40; n++) begin
      drive(1'b0, 1'b1, W'($urandom), W'($urandom), "R7");
      for (int i = 0; i < 8; i++)
        drive(1'($urandom_range(0, 3) != 0), 1'b0, W'($urandom), W'($urandom), "R2_R3_R4_R6");
    end

    drive(1'b0, 1'b0, '0, '0, "R6");
    @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule